// File: doc/BRIEF.md
# Turing machine rule engine

This block executes a Turing machine whose behaviour is held in a writable rule table, working over a finite tape stored in on-chip flops. Each rule links a (state, symbol read) pair to a symbol to write, a head direction and a follow-on state. Nothing about the machine is fixed in decode logic. The next state comes from scanning the stored table one entry per clock.

The host first loads rules through a write port and preloads the tape through a cell-addressed port. It then pulses start with a start state, a halt state and an initial head position. While the engine runs, it repeats the same step:

- read the cell under the head;
- scan the table from entry 0 for the first match;
- write the rule's symbol into that cell;
- move the head one cell;
- adopt the rule's next state.

The run ends in one of three ways: the machine reaches the halt state, no rule matches, or a move would leave the tape. After the run, the host reads the tape back through the same port. A live step count lets a supervisor put a bound on machines that never halt.

Top module: `tm_engine`

## Requirements
- R1: A rule word is packed as [16:13] current state, [12:9] symbol read, [8:5] symbol written, [4] direction (1 = right, head+1; 0 = left, head-1), [3:0] next state. Asserting rule_we_i stores rule_wdata_i at entry rule_addr_i. Asserting tape_we_i writes tape_wdata_i into cell tape_addr_i. tape_rdata_o shows cell tape_addr_i combinationally.
- R2: start_i, when not busy, latches the start state, halt state and head. It clears the step count and all outcome flags. The start edge is cycle 1 of the run. If the start state equals the halt state, the engine stops at that edge with halted_o=1 and zero steps. start_i while busy_o=1 has no effect.
- R3: One step writes the matched rule's written symbol into the head cell, moves the head by exactly one cell in the rule's direction, and sets the state to the rule's next state.
- R4: Every step scans from entry 0 upward, one entry per cycle, and the lowest-index match wins. A step matched at entry k takes k+1 cycles.
- R5: A step whose next state equals the halt state ends the run at that step's edge with done_o=1 and halted_o=1.
- R6: If no entry matches after all N_RULES entries are examined (N_RULES cycles), the run ends with err_norule_o=1. State, head and tape are unchanged by that failed search.
- R7: A left move from cell 0 or a right move from cell TAPE_LEN-1 ends the run with err_edge_o=1. The written symbol is stored. Head, state and step count keep their pre-step values. There is no wraparound.
- R8: step_cnt_o counts applied steps. It is readable while running and increments by one per completed step.
- R9: Host tape writes while busy_o=1 are ignored.
- R10: While busy, no outcome flag is set. When done_o=1 exactly one of halted_o, err_norule_o, err_edge_o is set, and the outputs hold until the next start.
- R11: After reset the engine is idle, with done_o, busy_o and all flags at 0, and step count, state and head at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rule_we_i | input | 1 | Rule table write strobe |
| rule_addr_i | input | 5 | Rule entry index |
| rule_wdata_i | input | 17 | Packed rule word |
| tape_we_i | input | 1 | Host tape write strobe |
| tape_addr_i | input | 6 | Host tape cell index |
| tape_wdata_i | input | 4 | Host tape write symbol |
| tape_rdata_o | output | 4 | Symbol of cell tape_addr_i |
| start_i | input | 1 | Start pulse |
| start_state_i | input | 4 | Initial state |
| halt_state_i | input | 4 | Halting state |
| start_head_i | input | 6 | Initial head cell |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished |
| halted_o | output | 1 | Finished in halt state |
| err_norule_o | output | 1 | Finished on a failed rule search |
| err_edge_o | output | 1 | Finished on a move off the tape |
| state_o | output | 4 | Current state |
| head_o | output | 6 | Current head cell |
| step_cnt_o | output | 32 | Applied step count |

## Verification
The engine's own tape write and a host tape write can land in the same cycle, and both may target the head cell. The bench runs a two-state machine that bounces forever between two cells. During that run it pulses host writes, one of them aimed at a cell the engine is rewriting, together with a stray start pulse. After a bounded number of steps and a reset, the tape is read back. The cells must hold only engine-written values, and the state and head must match the reference after the same number of steps. Random tables run against a bench model that also predicts the cycle count of every finished run.

// File: rtl/tm_pkg.sv
package tm_pkg;
  parameter int unsigned STATE_W = 4;
  parameter int unsigned SYM_W   = 4;

  typedef logic [STATE_W-1:0] state_t;
  typedef logic [SYM_W-1:0]   sym_t;

  typedef struct packed {
    state_t cur;
    sym_t   in_sym;
    sym_t   out_sym;
    logic   mv_right;
    state_t nxt;
  } rule_t;

  localparam int unsigned RULE_W = $bits(rule_t);

  typedef enum logic [1:0] {ST_IDLE, ST_SEARCH, ST_DONE} ctl_e;
endpackage

// File: rtl/tm_rule_table.sv
module tm_rule_table import tm_pkg::*; #(
  parameter int N_RULES = 32,
  parameter int IDX_W   = $clog2(N_RULES)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  rule_t            wdata_i,
  input  logic [IDX_W-1:0] raddr_i,
  output rule_t            rdata_o
);
  rule_t mem_q [N_RULES];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/tm_tape.sv
module tm_tape import tm_pkg::*; #(
  parameter int TAPE_LEN = 64,
  parameter int HEAD_W   = $clog2(TAPE_LEN)
) (
  input  logic              clk_i,
  input  logic              host_we_i,
  input  logic [HEAD_W-1:0] host_addr_i,
  input  sym_t              host_wdata_i,
  output sym_t              host_rdata_o,
  input  logic              eng_we_i,
  input  logic [HEAD_W-1:0] eng_addr_i,
  input  sym_t              eng_wdata_i,
  output sym_t              eng_rdata_o
);
  sym_t cells [TAPE_LEN];

  for (genvar g = 0; g < TAPE_LEN; g++) begin : g_cell
    sym_t cell_q;
    // engine write wins over host
    always_ff @(posedge clk_i) begin
      if (eng_we_i && eng_addr_i == HEAD_W'(g))        cell_q <= eng_wdata_i;
      else if (host_we_i && host_addr_i == HEAD_W'(g)) cell_q <= host_wdata_i;
    end
    assign cells[g] = cell_q;
  end

  assign host_rdata_o = cells[host_addr_i];
  assign eng_rdata_o  = cells[eng_addr_i];
endmodule

// File: rtl/tm_ctrl.sv
module tm_ctrl import tm_pkg::*; #(
  parameter int N_RULES  = 32,
  parameter int TAPE_LEN = 64,
  parameter int STEP_W   = 32,
  parameter int IDX_W    = $clog2(N_RULES),
  parameter int HEAD_W   = $clog2(TAPE_LEN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  state_t            start_state_i,
  input  state_t            halt_state_i,
  input  logic [HEAD_W-1:0] start_head_i,
  input  rule_t             rule_i,
  input  sym_t              sym_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [HEAD_W-1:0] head_o,
  output state_t            state_o,
  output logic              tape_we_o,
  output sym_t              tape_wdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              halted_o,
  output logic              err_norule_o,
  output logic              err_edge_o,
  output logic [STEP_W-1:0] step_cnt_o
);
  ctl_e              st_q;
  state_t            state_q, halt_q;
  logic [HEAD_W-1:0] head_q;
  logic [IDX_W-1:0]  idx_q;
  logic [STEP_W-1:0] step_q;
  logic              halted_q, norule_q, edge_q;

  logic match, last, edge_hit;

  always_comb begin
    match    = (rule_i.cur == state_q) && (rule_i.in_sym == sym_i);
    last     = (idx_q == IDX_W'(N_RULES - 1));
    edge_hit = rule_i.mv_right ? (head_q == HEAD_W'(TAPE_LEN - 1))
                               : (head_q == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      state_q  <= '0;
      halt_q   <= '0;
      head_q   <= '0;
      idx_q    <= '0;
      step_q   <= '0;
      halted_q <= 1'b0;
      norule_q <= 1'b0;
      edge_q   <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE, ST_DONE: begin
          if (start_i) begin
            state_q  <= start_state_i;
            halt_q   <= halt_state_i;
            head_q   <= start_head_i;
            idx_q    <= '0;
            step_q   <= '0;
            norule_q <= 1'b0;
            edge_q   <= 1'b0;
            if (start_state_i == halt_state_i) begin
              halted_q <= 1'b1;
              st_q     <= ST_DONE;
            end else begin
              halted_q <= 1'b0;
              st_q     <= ST_SEARCH;
            end
          end
        end
        ST_SEARCH: begin
          if (match) begin
            if (edge_hit) begin
              // symbol written, head/state/count held
              edge_q <= 1'b1;
              st_q   <= ST_DONE;
            end else begin
              head_q  <= rule_i.mv_right ? head_q + 1'b1 : head_q - 1'b1;
              state_q <= rule_i.nxt;
              step_q  <= step_q + 1'b1;
              idx_q   <= '0;
              if (rule_i.nxt == halt_q) begin
                halted_q <= 1'b1;
                st_q     <= ST_DONE;
              end
            end
          end else if (last) begin
            norule_q <= 1'b1;
            st_q     <= ST_DONE;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign idx_o        = idx_q;
  assign head_o       = head_q;
  assign state_o      = state_q;
  assign tape_we_o    = (st_q == ST_SEARCH) && match;
  assign tape_wdata_o = rule_i.out_sym;
  assign busy_o       = (st_q == ST_SEARCH);
  assign done_o       = (st_q == ST_DONE);
  assign halted_o     = halted_q;
  assign err_norule_o = norule_q;
  assign err_edge_o   = edge_q;
  assign step_cnt_o   = step_q;
endmodule

// File: rtl/tm_engine.sv
module tm_engine import tm_pkg::*; #(
  parameter  int N_RULES  = 32,
  parameter  int TAPE_LEN = 64,
  parameter  int STEP_W   = 32,
  localparam int IDX_W    = $clog2(N_RULES),
  localparam int HEAD_W   = $clog2(TAPE_LEN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rule_we_i,
  input  logic [IDX_W-1:0]  rule_addr_i,
  input  logic [RULE_W-1:0] rule_wdata_i,
  input  logic              tape_we_i,
  input  logic [HEAD_W-1:0] tape_addr_i,
  input  logic [SYM_W-1:0]  tape_wdata_i,
  output logic [SYM_W-1:0]  tape_rdata_o,
  input  logic              start_i,
  input  logic [STATE_W-1:0] start_state_i,
  input  logic [STATE_W-1:0] halt_state_i,
  input  logic [HEAD_W-1:0] start_head_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              halted_o,
  output logic              err_norule_o,
  output logic              err_edge_o,
  output logic [STATE_W-1:0] state_o,
  output logic [HEAD_W-1:0] head_o,
  output logic [STEP_W-1:0] step_cnt_o
);
  rule_t             cur_rule;
  sym_t              head_sym, eng_wdata;
  logic [IDX_W-1:0]  idx;
  logic              eng_we;

  tm_rule_table #(.N_RULES(N_RULES), .IDX_W(IDX_W)) u_rules (
    .clk_i   (clk_i),
    .we_i    (rule_we_i && !busy_o),
    .waddr_i (rule_addr_i),
    .wdata_i (rule_t'(rule_wdata_i)),
    .raddr_i (idx),
    .rdata_o (cur_rule)
  );

  tm_tape #(.TAPE_LEN(TAPE_LEN), .HEAD_W(HEAD_W)) u_tape (
    .clk_i        (clk_i),
    .host_we_i    (tape_we_i && !busy_o),
    .host_addr_i  (tape_addr_i),
    .host_wdata_i (tape_wdata_i),
    .host_rdata_o (tape_rdata_o),
    .eng_we_i     (eng_we),
    .eng_addr_i   (head_o),
    .eng_wdata_i  (eng_wdata),
    .eng_rdata_o  (head_sym)
  );

  tm_ctrl #(
    .N_RULES(N_RULES), .TAPE_LEN(TAPE_LEN), .STEP_W(STEP_W),
    .IDX_W(IDX_W), .HEAD_W(HEAD_W)
  ) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start_i),
    .start_state_i (start_state_i),
    .halt_state_i  (halt_state_i),
    .start_head_i  (start_head_i),
    .rule_i        (cur_rule),
    .sym_i         (head_sym),
    .idx_o         (idx),
    .head_o        (head_o),
    .state_o       (state_o),
    .tape_we_o     (eng_we),
    .tape_wdata_o  (eng_wdata),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .halted_o      (halted_o),
    .err_norule_o  (err_norule_o),
    .err_edge_o    (err_edge_o),
    .step_cnt_o    (step_cnt_o)
  );
endmodule

// File: rtl/tm_engine_chk.sv
module tm_engine_chk #(
  parameter int TAPE_LEN = 64,
  parameter int STEP_W   = 32,
  parameter int HEAD_W   = 6,
  parameter int STATE_W  = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic               busy_o,
  input logic               done_o,
  input logic               halted_o,
  input logic               err_norule_o,
  input logic               err_edge_o,
  input logic [STATE_W-1:0] state_o,
  input logic [HEAD_W-1:0]  head_o,
  input logic [STEP_W-1:0]  step_cnt_o
);
  AST_FLAGS_CLEAR_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !(halted_o || err_norule_o || err_edge_o)); // R10

  AST_ONE_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $countones({halted_o, err_norule_o, err_edge_o}) == 1); // R10

  AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o && $stable(step_cnt_o) && $stable(head_o) && $stable(state_o)); // R10

  AST_HEAD_UNIT_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> head_o == $past(head_o) ||
                                head_o == $past(head_o) + HEAD_W'(1) ||
                                head_o == $past(head_o) - HEAD_W'(1)); // R3

  AST_STEP_WITH_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) && step_cnt_o != $past(step_cnt_o) |->
      step_cnt_o == $past(step_cnt_o) + STEP_W'(1) && head_o != $past(head_o)); // R8

  AST_START_CLEARS_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> step_cnt_o == '0); // R2

  AST_NOMATCH_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_norule_o) |-> head_o == $past(head_o) && state_o == $past(state_o)); // R6

  AST_EDGE_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_edge_o) |-> head_o == '0 || head_o == HEAD_W'(TAPE_LEN - 1)); // R7

  AST_HALT_CHANGES_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halted_o) && $past(busy_o) |-> state_o != $past(state_o)); // R5
endmodule

bind tm_engine tm_engine_chk #(
  .TAPE_LEN(TAPE_LEN), .STEP_W(STEP_W), .HEAD_W(HEAD_W), .STATE_W(tm_pkg::STATE_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .halted_o     (halted_o),
  .err_norule_o (err_norule_o),
  .err_edge_o   (err_edge_o),
  .state_o      (state_o),
  .head_o       (head_o),
  .step_cnt_o   (step_cnt_o)
);

// File: tb/sim_tm_engine.sv
`timescale 1ns/1ps
module sim_tm_engine;
  import tm_pkg::*;

  localparam int NR = 32;
  localparam int TL = 64;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rule_we_i = 1'b0;
  logic [4:0]  rule_addr_i = '0;
  logic [RULE_W-1:0] rule_wdata_i = '0;
  logic        tape_we_i = 1'b0;
  logic [5:0]  tape_addr_i = '0;
  logic [3:0]  tape_wdata_i = '0;
  logic [3:0]  tape_rdata_o;
  logic        start_i = 1'b0;
  logic [3:0]  start_state_i = '0;
  logic [3:0]  halt_state_i = '0;
  logic [5:0]  start_head_i = '0;
  logic        busy_o, done_o, halted_o, err_norule_o, err_edge_o;
  logic [3:0]  state_o;
  logic [5:0]  head_o;
  logic [31:0] step_cnt_o;

  always #2.5 clk = ~clk;

  tm_engine u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .rule_we_i(rule_we_i), .rule_addr_i(rule_addr_i), .rule_wdata_i(rule_wdata_i),
    .tape_we_i(tape_we_i), .tape_addr_i(tape_addr_i), .tape_wdata_i(tape_wdata_i),
    .tape_rdata_o(tape_rdata_o),
    .start_i(start_i), .start_state_i(start_state_i), .halt_state_i(halt_state_i),
    .start_head_i(start_head_i),
    .busy_o(busy_o), .done_o(done_o), .halted_o(halted_o),
    .err_norule_o(err_norule_o), .err_edge_o(err_edge_o),
    .state_o(state_o), .head_o(head_o), .step_cnt_o(step_cnt_o)
  );

  int n_checks = 0;
  int n_fail   = 0;

  rule_t m_rule [NR];
  sym_t  m_tape [TL];
  int    m_state, m_head, m_steps, m_cyc, m_kind; // kind: 0 running,1 halt,2 norule,3 edge

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic load_hw();
    for (int i = 0; i < NR; i++) begin
      @(negedge clk);
      rule_we_i = 1'b1; rule_addr_i = 5'(i); rule_wdata_i = m_rule[i];
    end
    for (int i = 0; i < TL; i++) begin
      @(negedge clk);
      rule_we_i = 1'b0;
      tape_we_i = 1'b1; tape_addr_i = 6'(i); tape_wdata_i = m_tape[i];
    end
    @(negedge clk);
    rule_we_i = 1'b0; tape_we_i = 1'b0;
  endtask

  task automatic model_run(input int s0, input int hs, input int h0, input int limit);
    m_state = s0; m_head = h0; m_steps = 0; m_cyc = 1; m_kind = 0;
    if (s0 == hs) begin m_kind = 1; return; end
    while (m_steps < limit) begin
      int k = -1;
      for (int i = 0; i < NR; i++)
        if (int'(m_rule[i].cur) == m_state && m_rule[i].in_sym == m_tape[m_head]) begin
          k = i; break;
        end
      if (k < 0) begin m_cyc += NR; m_kind = 2; return; end
      m_cyc += k + 1;
      m_tape[m_head] = m_rule[k].out_sym;
      if ((m_rule[k].mv_right && m_head == TL - 1) || (!m_rule[k].mv_right && m_head == 0)) begin
        m_kind = 3; return;
      end
      m_head  = m_rule[k].mv_right ? m_head + 1 : m_head - 1;
      m_state = int'(m_rule[k].nxt);
      m_steps++;
      if (m_state == hs) begin m_kind = 1; return; end
    end
  endtask

  task automatic check_tape(input string req);
    int bad = 0, first = -1;
    for (int i = 0; i < TL; i++) begin
      tape_addr_i = 6'(i);
      #0.1;
      if (tape_rdata_o !== m_tape[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    end
    if (first < 0) first = 0;
    tape_addr_i = 6'(first);
    #0.1;
    chk(bad == 0, req, "tape cell", tape_rdata_o, m_tape[first]);
  endtask

  // loads hardware from model arrays, runs both, compares
  task automatic run_case(input int s0, input int hs, input int h0, input int limit,
                          input string req);
    int cyc;
    load_hw();
    model_run(s0, hs, h0, limit);
    start_state_i = 4'(s0); halt_state_i = 4'(hs); start_head_i = 6'(h0);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    cyc = 1;
    while (busy_o && cyc < 60000 && !(m_kind == 0 && step_cnt_o == 32'(limit))) begin
      @(negedge clk);
      cyc++;
    end
    if (m_kind == 0) begin
      chk(busy_o == 1'b1, "R8", "busy at step bound", busy_o, 1);
      chk(step_cnt_o == 32'(limit), "R8", "step count at bound", step_cnt_o, limit);
      chk(state_o == 4'(m_state), "R3", "state at bound", state_o, m_state);
      chk(head_o == 6'(m_head), "R3", "head at bound", head_o, m_head);
      do_reset();
    end else begin
      chk(done_o && !busy_o, req, "done", done_o, 1);
      chk(halted_o == (m_kind == 1), "R5", "halted flag", halted_o, m_kind == 1);
      chk(err_norule_o == (m_kind == 2), "R6", "no-rule flag", err_norule_o, m_kind == 2);
      chk(err_edge_o == (m_kind == 3), "R7", "edge flag", err_edge_o, m_kind == 3);
      chk(cyc == m_cyc, "R4", "run cycles", cyc, m_cyc);
      chk(state_o == 4'(m_state), req, "final state", state_o, m_state);
      chk(head_o == 6'(m_head), req, "final head", head_o, m_head);
      chk(step_cnt_o == 32'(m_steps), "R8", "final steps", step_cnt_o, m_steps);
      check_tape(req);
    end
  endtask

  task automatic fill_dummy();
    for (int i = 0; i < NR; i++) m_rule[i] = '{cur: 4'd13, in_sym: 4'd0, out_sym: 4'd0,
                                             mv_right: 1'b0, nxt: 4'd13};
    for (int i = 0; i < TL; i++) m_tape[i] = 4'(i % 3);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk(!busy_o && !done_o && !halted_o && !err_norule_o && !err_edge_o, "R11",
        "flags after reset", {busy_o, done_o, halted_o, err_norule_o, err_edge_o}, 0);
    chk(step_cnt_o == 0 && state_o == 0 && head_o == 0, "R11", "counters after reset",
        step_cnt_o + state_o + head_o, 0);

    // R1 tape preload and readback
    fill_dummy();
    load_hw();
    check_tape("R1");

    // R2 start state equals halt state
    fill_dummy();
    run_case(7, 7, 12, 100, "R2");

    // R4 only match at last entry, R5 halt
    fill_dummy();
    m_rule[31] = '{cur: 4'd0, in_sym: 4'd1, out_sym: 4'd5, mv_right: 1'b1, nxt: 4'd15};
    run_case(0, 15, 10, 100, "R4");
    chk(m_cyc == 33, "R4", "bench model last-entry latency", m_cyc, 33);

    // R4 priority: two matching entries, lower index wins
    fill_dummy();
    m_rule[7] = '{cur: 4'd2, in_sym: 4'd0, out_sym: 4'd9, mv_right: 1'b0, nxt: 4'd15};
    m_rule[3] = '{cur: 4'd2, in_sym: 4'd0, out_sym: 4'd6, mv_right: 1'b1, nxt: 4'd15};
    run_case(2, 15, 30, 100, "R4");

    // R6 no match anywhere
    fill_dummy();
    run_case(0, 15, 40, 100, "R6");

    // R7 left edge and right edge
    fill_dummy();
    m_rule[0] = '{cur: 4'd0, in_sym: 4'd0, out_sym: 4'd7, mv_right: 1'b0, nxt: 4'd1};
    run_case(0, 15, 0, 100, "R7");
    fill_dummy();
    m_rule[5] = '{cur: 4'd1, in_sym: 4'd0, out_sym: 4'd8, mv_right: 1'b1, nxt: 4'd2};
    run_case(1, 15, 63, 100, "R7");

    // R3 directed walk: write 1 moving right until symbol 2 met
    fill_dummy();
    for (int i = 0; i < TL; i++) m_tape[i] = 4'd0;
    m_tape[20] = 4'd2;
    m_rule[0] = '{cur: 4'd0, in_sym: 4'd0, out_sym: 4'd1, mv_right: 1'b1, nxt: 4'd0};
    m_rule[1] = '{cur: 4'd0, in_sym: 4'd2, out_sym: 4'd3, mv_right: 1'b0, nxt: 4'd15};
    run_case(0, 15, 12, 100, "R3");

    // R9 / R2: host write and stray start during a run that never halts
    fill_dummy();
    for (int y = 0; y < 16; y++) begin
      m_rule[y]      = '{cur: 4'd0, in_sym: 4'(y), out_sym: 4'(y), mv_right: 1'b1, nxt: 4'd1};
      m_rule[16 + y] = '{cur: 4'd1, in_sym: 4'(y), out_sym: 4'(y), mv_right: 1'b0, nxt: 4'd0};
    end
    m_tape[50] = 4'd3;
    m_tape[20] = 4'd2;
    load_hw();
    model_run(0, 15, 20, 60);
    start_state_i = 4'd0; halt_state_i = 4'd15; start_head_i = 6'd20;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (20) @(negedge clk);
    tape_we_i = 1'b1; tape_addr_i = 6'd50; tape_wdata_i = 4'd9;
    @(negedge clk);
    tape_addr_i = 6'd20;
    start_i = 1'b1; start_state_i = 4'd15; start_head_i = 6'd5;
    repeat (40) @(negedge clk);
    tape_we_i = 1'b0; start_i = 1'b0;
    for (int c = 0; c < 5000 && step_cnt_o != 32'd60; c++) @(negedge clk);
    chk(busy_o == 1'b1, "R2", "start ignored while busy", busy_o, 1);
    chk(step_cnt_o == 32'd60, "R8", "step count reaches bound", step_cnt_o, 60);
    chk(state_o == 4'(m_state) && head_o == 6'(m_head), "R2", "state/head after stray start",
        {state_o, head_o}, {4'(m_state), 6'(m_head)});
    do_reset();
    tape_addr_i = 6'd50; #0.1;
    chk(tape_rdata_o == 4'd3, "R9", "cell 50 after busy write", tape_rdata_o, 3);
    tape_addr_i = 6'd20; #0.1;
    chk(tape_rdata_o == 4'd2, "R9", "head cell after busy write", tape_rdata_o, 2);

    // random machines
    for (int t = 0; t < 24; t++) begin
      int s0, h0;
      fill_dummy();
      for (int s = 0; s < 4; s++)
        for (int y = 0; y < 3; y++)
          if ($urandom % 10 != 0) begin
            int slot = int'($urandom % NR);
            m_rule[slot] = '{cur: 4'(s), in_sym: 4'(y), out_sym: 4'($urandom % 3),
                             mv_right: 1'($urandom % 2), nxt: 4'($urandom % 5)};
          end
      for (int i = 0; i < TL; i++) m_tape[i] = 4'($urandom % 3);
      s0 = int'($urandom % 5);
      h0 = (t % 4 == 0) ? int'($urandom % 4) : int'($urandom % TL);
      run_case(s0, 4, h0, 100, "R3");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule